// File: doc/BRIEF.md
# Interrupt and Exception Entry Sequencer

This block sits inside a small processor core and decides when control leaves the running program for a handler. At an instruction boundary it looks at four event sources: a synchronous exception reported by the core, a software interrupt instruction, a non-maskable interrupt line, and a maskable request line. The maskable line only counts while the interrupt-enable bit of the core's flag word is set. Inside a repeated string operation, the core also offers a gap between element moves. In that gap only the two hardware sources may enter.

Once an event is chosen, the block settles the 8-bit vector. An exception or software interrupt brings its own vector. The non-maskable line uses a fixed vector. A maskable request fetches its vector through an acknowledge handshake. The return address is chosen by event class. The block then pushes the flags and the return address through a simple word memory port. Next it reads the handler pointer from a vector table whose entry size depends on the operating mode, and it hands the pointer to the core. A return command pops the saved state in reverse order.

States: `ST_IDLE`, `ST_INTA`, `ST_PUSH_FLAGS`, `ST_PUSH_RET`, `ST_FETCH_LO`, `ST_FETCH_HI`, `ST_ENTER`, `ST_POP_RET`, `ST_POP_FLAGS` and `ST_RETURN`.

Transitions:
- `ST_IDLE` goes to `ST_POP_RET` when a return is requested at a boundary.
- Otherwise `ST_IDLE` goes to `ST_INTA` for a maskable request, or to `ST_PUSH_FLAGS` for any other taken event.
- `ST_INTA` goes to `ST_PUSH_FLAGS` on acknowledge.
- `ST_PUSH_FLAGS` goes to `ST_PUSH_RET` on memory acknowledge, and `ST_PUSH_RET` goes to `ST_FETCH_LO` on memory acknowledge.
- `ST_FETCH_LO` goes to `ST_FETCH_HI` in protected mode, or to `ST_ENTER` in real mode.
- `ST_FETCH_HI` goes to `ST_ENTER`.
- `ST_ENTER` goes to `ST_IDLE`.
- `ST_POP_RET` goes to `ST_POP_FLAGS`, which goes to `ST_RETURN`.
- `ST_RETURN` goes to `ST_IDLE`.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `mem_req`, `inta_req`, `handler_valid` and `ret_valid` are low, and the stack pointer equals STACK_INIT (default 0x8000).
- R2: At one boundary, the event taken follows this order: exception first, then software interrupt, then non-maskable interrupt, then maskable interrupt. A return request (`iret` with `at_boundary`) is served before all of them.
- R3: A maskable request is taken only when `intr` is high and bit 9 of `flags_in` is 1. Its vector is the value on `inta_vector` in the cycle `inta_ack` is high. `inta_req` stays high until that acknowledge.
- R4: A rising edge on `nmi` is latched as pending and taken with vector 2. After it is taken, further non-maskable entries are blocked until the next return completes; an edge seen meanwhile stays pending.
- R5: Exceptions and software interrupts are taken only when `at_boundary` is high. Non-maskable and maskable interrupts are taken when `at_boundary` or `str_gap` is high. With neither high, no entry starts.
- R6: The saved return address depends on the event:

  | Event | Saved address |
  |---|---|
  | Fault (`exc_cls` 00) | `cur_ip` |
  | Trap (`exc_cls` 01) | `next_ip` |
  | Abort (`exc_cls` 10) | `cur_ip`, and `abort_hit` is high in the entry cycle |
  | Software interrupt | `next_ip` |
  | Hardware interrupt at a boundary | `next_ip` |
  | Hardware interrupt in a string gap | `cur_ip` |

  Code 11 of `exc_cls` is treated as a fault.
- R7: On entry, the zero-extended flags are written to SP-4 first, then the return address is written to SP-8. The stack pointer ends at SP-8.
- R8: The table entry address depends on the mode:
  - Real mode (`prot_mode`=0): base+vector×4, read as one word. The handler pointer is that word.
  - Protected mode: base+vector×8 and base+vector×8+4. The handler pointer is {upper half of the second word, lower half of the first word}.
- R9: The entry ends with `handler_valid` high for exactly one cycle, directly after the last table read, carrying the vector and the pointer. `if_clear` is high in that cycle only for non-maskable and maskable entries.
- R10: A return reads the return address at SP, then the flags at SP+4, and raises `ret_valid` for one cycle with `ret_addr` and `flags_out`. The stack pointer ends at SP+8.
- R11: While `mem_req` is high and `mem_ack` is low, the request, its direction and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| at_boundary | input | 1 | Core is between two instructions |
| str_gap | input | 1 | Core is between element moves of a repeated string operation |
| exc_valid | input | 1 | Exception reported by the core |
| exc_cls | input | 2 | Exception class: 00 fault, 01 trap, 10 abort |
| exc_vector | input | 8 | Exception vector |
| swi_valid | input | 1 | Software interrupt instruction completed |
| swi_vector | input | 8 | Vector carried by the instruction |
| nmi | input | 1 | Non-maskable interrupt line (edge sensitive) |
| intr | input | 1 | Maskable interrupt request line |
| flags_in | input | 16 | Current flag word; bit 9 enables maskable requests |
| cur_ip | input | 32 | Address of the current instruction, prefixes included |
| next_ip | input | 32 | Address of the following instruction |
| prot_mode | input | 1 | 1 selects 8-byte table entries |
| table_base | input | 32 | Vector table base address |
| iret | input | 1 | Return-from-handler command |
| inta_req | output | 1 | Interrupt acknowledge request |
| inta_ack | input | 1 | Acknowledge completed |
| inta_vector | input | 8 | Vector returned by the acknowledge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Memory access completed |
| handler_valid | output | 1 | One-cycle handler entry strobe |
| handler_vector | output | 8 | Vector of the entry |
| handler_ptr | output | 32 | Handler pointer from the table |
| abort_hit | output | 1 | Entry is an abort; saved address is imprecise |
| if_clear | output | 1 | Core must clear its interrupt-enable bit |
| ret_valid | output | 1 | One-cycle return completion strobe |
| ret_addr | output | 32 | Restored return address |
| flags_out | output | 16 | Restored flag word |

## Verification
The bench raises an exception, a software interrupt and a maskable request at the same boundary, and checks that only the exception is taken; a wrong order would push the other vector's frame. Faults, traps and aborts are compared against each other on the saved address, and a hardware request inside a string gap is also checked. A design that always saved the next address would restart faults one instruction late and skip the rest of an interrupted string move. A second non-maskable edge during a blocked handler must stay pending and enter only after the return: a design that dropped it would lose the event, and one that nested it would push an unexpected frame. Both table modes are exercised, vector 255 included, so a wrong entry scale or half-word merge yields a wrong handler pointer.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INTA,
        ST_PUSH_FLAGS,
        ST_PUSH_RET,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_ENTER,
        ST_POP_RET,
        ST_POP_FLAGS,
        ST_RETURN
    } seq_state_t;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_EXC,
        SRC_SWI,
        SRC_NMI,
        SRC_INTR
    } irq_src_t;

    localparam logic [1:0] CLS_FAULT = 2'b00;
    localparam logic [1:0] CLS_TRAP  = 2'b01;
    localparam logic [1:0] CLS_ABORT = 2'b10;

    localparam logic [7:0] NMI_VECTOR = 8'd2;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          at_boundary,
    input  logic          str_gap,
    input  logic          exc_valid,
    input  logic [1:0]    exc_cls,
    input  logic [7:0]    exc_vector,
    input  logic          swi_valid,
    input  logic [7:0]    swi_vector,
    input  logic          nmi_ready,
    input  logic          intr_ok,
    input  logic [AW-1:0] cur_ip,
    input  logic [AW-1:0] next_ip,
    output logic          take,
    output irq_src_t      src,
    output logic [7:0]    vec,
    output logic [AW-1:0] ret,
    output logic          abort
);
    logic          hw_window;
    logic [AW-1:0] hw_ret;

    // a string gap resumes the same instruction; a boundary resumes the next
    assign hw_window = at_boundary | str_gap;
    assign hw_ret    = at_boundary ? next_ip : cur_ip;

    always_comb begin
        take  = 1'b0;
        src   = SRC_NONE;
        vec   = 8'd0;
        ret   = next_ip;
        abort = 1'b0;
        if (at_boundary && exc_valid) begin
            take  = 1'b1;
            src   = SRC_EXC;
            vec   = exc_vector;
            abort = (exc_cls == CLS_ABORT);
            ret   = (exc_cls == CLS_TRAP) ? next_ip : cur_ip;
        end else if (at_boundary && swi_valid) begin
            take = 1'b1;
            src  = SRC_SWI;
            vec  = swi_vector;
            ret  = next_ip;
        end else if (hw_window && nmi_ready) begin
            take = 1'b1;
            src  = SRC_NMI;
            vec  = NMI_VECTOR;
            ret  = hw_ret;
        end else if (hw_window && intr_ok) begin
            take = 1'b1;
            src  = SRC_INTR;
            ret  = hw_ret;
        end
    end

endmodule

// File: rtl/irq_nmi_gate.sv
module irq_nmi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi,
    input  logic take_nmi,
    input  logic release_blk,
    output logic nmi_ready,
    output logic nmi_blocked
);
    logic nmi_q;
    logic pending;
    logic edge_seen;

    assign edge_seen = nmi & ~nmi_q;
    assign nmi_ready = pending & ~nmi_blocked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q       <= 1'b0;
            pending     <= 1'b0;
            nmi_blocked <= 1'b0;
        end else begin
            nmi_q   <= nmi;
            pending <= edge_seen | (pending & ~take_nmi);
            if (take_nmi) begin
                nmi_blocked <= 1'b1;
            end else if (release_blk) begin
                nmi_blocked <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_table_addr.sv
module irq_table_addr #(
    parameter int AW           = 32,
    parameter bit PROT_SUPPORT = 1'b1
) (
    input  logic [AW-1:0] base,
    input  logic [7:0]    vec,
    input  logic          prot_mode,
    input  logic          hi_word,
    output logic [AW-1:0] addr,
    output logic          wide
);
    localparam int WB = AW / 8;
    localparam int SH = $clog2(WB);

    logic [AW-1:0] offset;

    generate
        if (PROT_SUPPORT) begin : g_prot
            assign wide = prot_mode;
        end else begin : g_real
            logic unused_mode;
            assign unused_mode = prot_mode;
            assign wide        = 1'b0;
        end
    endgenerate

    // real: one word per entry; protected: two words per entry
    assign offset = wide ? (AW'(vec) << (SH + 1)) : (AW'(vec) << SH);
    assign addr   = base + offset + (hi_word ? AW'(WB) : AW'(0));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int            AW           = 32,
    parameter int            FW           = 16,
    parameter int            IF_BIT       = 9,
    parameter logic [31:0]   STACK_INIT   = 32'h0000_8000,
    parameter bit            PROT_SUPPORT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          at_boundary,
    input  logic          str_gap,
    input  logic          exc_valid,
    input  logic [1:0]    exc_cls,
    input  logic [7:0]    exc_vector,
    input  logic          swi_valid,
    input  logic [7:0]    swi_vector,
    input  logic          nmi,
    input  logic          intr,
    input  logic [FW-1:0] flags_in,
    input  logic [AW-1:0] cur_ip,
    input  logic [AW-1:0] next_ip,
    input  logic          prot_mode,
    input  logic [AW-1:0] table_base,
    input  logic          iret,
    output logic          inta_req,
    input  logic          inta_ack,
    input  logic [7:0]    inta_vector,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          handler_valid,
    output logic [7:0]    handler_vector,
    output logic [AW-1:0] handler_ptr,
    output logic          abort_hit,
    output logic          if_clear,
    output logic          ret_valid,
    output logic [AW-1:0] ret_addr,
    output logic [FW-1:0] flags_out
);
    localparam int WB = AW / 8;
    localparam int HW = AW / 2;

    seq_state_t    state, state_nx;

    logic          arb_take;
    irq_src_t      arb_src;
    logic [7:0]    arb_vec;
    logic [AW-1:0] arb_ret;
    logic          arb_abort;
    logic          intr_ok;
    logic          nmi_ready;
    logic          nmi_blocked;
    logic          ret_go;
    logic          entry_go;
    logic          take_nmi;

    logic [AW-1:0] sp;
    irq_src_t      cur_src;
    logic [7:0]    cur_vec;
    logic [AW-1:0] cur_ret;
    logic          cur_abort;
    logic [FW-1:0] cur_flags;
    logic [HW-1:0] lo_half;
    logic [AW-1:0] hand_ptr;
    logic [AW-1:0] pop_ret;
    logic [FW-1:0] pop_flags;

    logic [AW-1:0] tbl_addr;
    logic          tbl_wide;

    assign intr_ok  = intr & flags_in[IF_BIT];
    assign ret_go   = (state == ST_IDLE) && iret && at_boundary;
    assign entry_go = (state == ST_IDLE) && !ret_go && arb_take;
    assign take_nmi = entry_go && (arb_src == SRC_NMI);

    irq_arbiter #(.AW(AW)) u_arb (
        .at_boundary (at_boundary),
        .str_gap     (str_gap),
        .exc_valid   (exc_valid),
        .exc_cls     (exc_cls),
        .exc_vector  (exc_vector),
        .swi_valid   (swi_valid),
        .swi_vector  (swi_vector),
        .nmi_ready   (nmi_ready),
        .intr_ok     (intr_ok),
        .cur_ip      (cur_ip),
        .next_ip     (next_ip),
        .take        (arb_take),
        .src         (arb_src),
        .vec         (arb_vec),
        .ret         (arb_ret),
        .abort       (arb_abort)
    );

    irq_nmi_gate u_nmi (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi         (nmi),
        .take_nmi    (take_nmi),
        .release_blk (state == ST_RETURN),
        .nmi_ready   (nmi_ready),
        .nmi_blocked (nmi_blocked)
    );

    irq_table_addr #(.AW(AW), .PROT_SUPPORT(PROT_SUPPORT)) u_tbl (
        .base      (table_base),
        .vec       (cur_vec),
        .prot_mode (prot_mode),
        .hi_word   (state == ST_FETCH_HI),
        .addr      (tbl_addr),
        .wide      (tbl_wide)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ret_go) begin
                    state_nx = ST_POP_RET;
                end else if (arb_take) begin
                    state_nx = (arb_src == SRC_INTR) ? ST_INTA : ST_PUSH_FLAGS;
                end
            end
            ST_INTA:       if (inta_ack) state_nx = ST_PUSH_FLAGS;
            ST_PUSH_FLAGS: if (mem_ack)  state_nx = ST_PUSH_RET;
            ST_PUSH_RET:   if (mem_ack)  state_nx = ST_FETCH_LO;
            ST_FETCH_LO:   if (mem_ack)  state_nx = tbl_wide ? ST_FETCH_HI : ST_ENTER;
            ST_FETCH_HI:   if (mem_ack)  state_nx = ST_ENTER;
            ST_ENTER:                    state_nx = ST_IDLE;
            ST_POP_RET:    if (mem_ack)  state_nx = ST_POP_FLAGS;
            ST_POP_FLAGS:  if (mem_ack)  state_nx = ST_RETURN;
            ST_RETURN:                   state_nx = ST_IDLE;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req        = 1'b0;
        mem_we         = 1'b0;
        mem_addr       = sp;
        mem_wdata      = '0;
        inta_req       = 1'b0;
        handler_valid  = 1'b0;
        abort_hit      = 1'b0;
        if_clear       = 1'b0;
        ret_valid      = 1'b0;
        handler_vector = cur_vec;
        handler_ptr    = hand_ptr;
        ret_addr       = pop_ret;
        flags_out      = pop_flags;
        unique case (state)
            ST_INTA: inta_req = 1'b1;
            ST_PUSH_FLAGS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp - AW'(WB);
                mem_wdata = AW'(cur_flags);
            end
            ST_PUSH_RET: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp - AW'(WB);
                mem_wdata = cur_ret;
            end
            ST_FETCH_LO, ST_FETCH_HI: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
            end
            ST_ENTER: begin
                handler_valid = 1'b1;
                abort_hit     = cur_abort;
                if_clear      = (cur_src == SRC_NMI) || (cur_src == SRC_INTR);
            end
            ST_POP_RET, ST_POP_FLAGS: mem_req = 1'b1;
            ST_RETURN: ret_valid = 1'b1;
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp        <= AW'(STACK_INIT);
            cur_src   <= SRC_NONE;
            cur_vec   <= '0;
            cur_ret   <= '0;
            cur_abort <= 1'b0;
            cur_flags <= '0;
            lo_half   <= '0;
            hand_ptr  <= '0;
            pop_ret   <= '0;
            pop_flags <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (entry_go) begin
                        cur_src   <= arb_src;
                        cur_vec   <= arb_vec;
                        cur_ret   <= arb_ret;
                        cur_abort <= arb_abort;
                        cur_flags <= flags_in;
                    end
                end
                ST_INTA: if (inta_ack) cur_vec <= inta_vector;
                ST_PUSH_FLAGS, ST_PUSH_RET: if (mem_ack) sp <= sp - AW'(WB);
                ST_FETCH_LO: begin
                    if (mem_ack) begin
                        lo_half  <= mem_rdata[HW-1:0];
                        hand_ptr <= mem_rdata;
                    end
                end
                ST_FETCH_HI: if (mem_ack) hand_ptr <= {mem_rdata[AW-1:HW], lo_half};
                ST_POP_RET: begin
                    if (mem_ack) begin
                        pop_ret <= mem_rdata;
                        sp      <= sp + AW'(WB);
                    end
                end
                ST_POP_FLAGS: begin
                    if (mem_ack) begin
                        pop_flags <= mem_rdata[FW-1:0];
                        sp        <= sp + AW'(WB);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
    import irq_seq_pkg::*;
#(
    parameter int IF_BIT = 9
) (
    input logic       clk,
    input logic       rst_n,
    input seq_state_t state,
    input irq_src_t   cur_src,
    input logic       nmi_blocked,
    input logic       at_boundary,
    input logic       str_gap,
    input logic       iret,
    input logic       exc_valid,
    input logic       nmi_ready,
    input logic       intr,
    input logic [15:0] flags_in,
    input logic       inta_req,
    input logic       mem_req,
    input logic       mem_we,
    input logic [31:0] mem_addr,
    input logic       mem_ack,
    input logic       handler_valid,
    input logic [7:0] handler_vector,
    input logic       if_clear,
    input logic       ret_valid
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11

    AST_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !at_boundary && !str_gap) |=> (state == ST_IDLE)); // R5

    AST_GAP_HW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !at_boundary && str_gap && !nmi_ready
         && !(intr && flags_in[IF_BIT])) |=> (state == ST_IDLE)); // R5

    AST_PRIO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && at_boundary && !iret && exc_valid) |=> (cur_src == SRC_EXC)); // R2

    AST_INTA_MASKABLE: assert property (@(posedge clk) disable iff (!rst_n)
        inta_req |-> (cur_src == SRC_INTR)); // R3

    AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_valid && cur_src == SRC_NMI) |-> (handler_vector == NMI_VECTOR)); // R4

    AST_NMI_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_blocked && state == ST_IDLE) |=> !(state == ST_PUSH_FLAGS && cur_src == SRC_NMI)); // R4

    AST_IF_CLEAR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        if_clear |-> handler_valid); // R9

    AST_ENTRY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        handler_valid |-> $past(mem_req && mem_ack && !mem_we)); // R8

    AST_RET_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> $past(mem_req && mem_ack && !mem_we)); // R10

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.IF_BIT(IF_BIT)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .state          (state),
    .cur_src        (cur_src),
    .nmi_blocked    (nmi_blocked),
    .at_boundary    (at_boundary),
    .str_gap        (str_gap),
    .iret           (iret),
    .exc_valid      (exc_valid),
    .nmi_ready      (nmi_ready),
    .intr           (intr),
    .flags_in       (flags_in),
    .inta_req       (inta_req),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_ack        (mem_ack),
    .handler_valid  (handler_valid),
    .handler_vector (handler_vector),
    .if_clear       (if_clear),
    .ret_valid      (ret_valid)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        at_boundary = 1'b0, str_gap = 1'b0;
    logic        exc_valid = 1'b0;
    logic [1:0]  exc_cls = 2'b00;
    logic [7:0]  exc_vector = 8'd0;
    logic        swi_valid = 1'b0;
    logic [7:0]  swi_vector = 8'd0;
    logic        nmi = 1'b0, intr = 1'b0;
    logic [15:0] flags_in = 16'h0202;
    logic [31:0] cur_ip = 32'h1000, next_ip = 32'h1004;
    logic        prot_mode = 1'b0;
    logic [31:0] table_base = 32'h0000_0100;
    logic        iret = 1'b0;
    logic        inta_req, inta_ack;
    logic [7:0]  inta_vector = 8'h41;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        handler_valid, abort_hit, if_clear, ret_valid;
    logic [7:0]  handler_vector;
    logic [31:0] handler_ptr, ret_addr;
    logic [15:0] flags_out;

    always #5 clk = ~clk;

    irq_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .str_gap(str_gap),
        .exc_valid(exc_valid), .exc_cls(exc_cls), .exc_vector(exc_vector),
        .swi_valid(swi_valid), .swi_vector(swi_vector), .nmi(nmi), .intr(intr),
        .flags_in(flags_in), .cur_ip(cur_ip), .next_ip(next_ip), .prot_mode(prot_mode),
        .table_base(table_base), .iret(iret), .inta_req(inta_req), .inta_ack(inta_ack),
        .inta_vector(inta_vector), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .handler_valid(handler_valid), .handler_vector(handler_vector),
        .handler_ptr(handler_ptr), .abort_hit(abort_hit), .if_clear(if_clear),
        .ret_valid(ret_valid), .ret_addr(ret_addr), .flags_out(flags_out)
    );

    // ---------------- memory and acknowledge models ----------------
    logic [31:0] mem [logic [31:0]];

    function automatic logic [31:0] tbl_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    always @* begin
        if (mem.exists(mem_addr)) mem_rdata = mem[mem_addr];
        else                      mem_rdata = tbl_word(mem_addr);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            inta_ack <= 1'b0;
        end else begin
            if (mem_req && mem_ack && mem_we) mem[mem_addr] = mem_wdata;
            mem_ack  <= mem_req && !mem_ack;
            inta_ack <= inta_req && !inta_ack;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        int          kind;   // 0 write, 1 entry, 2 return
        logic [31:0] a;
        logic [31:0] b;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0, errors = 0;
    bit          finished = 1'b0;
    logic [31:0] sp_m = 32'h8000;
    logic [31:0] fr_ret[$];
    logic [15:0] fr_flg[$];
    bit          in_req = 1'b0;
    logic [31:0] req_addr0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ptr_of(input logic [7:0] v, input bit prot);
        logic [31:0] a;
        a = prot ? table_base + {21'd0, v, 3'd0} : table_base + {22'd0, v, 2'd0};
        if (prot) return {tbl_word(a + 32'd4)[31:16], tbl_word(a)[15:0]};
        return tbl_word(a);
    endfunction

    task automatic expect_entry(input logic [7:0] v, input logic [15:0] fl, input logic [31:0] ra,
                                input bit ifc, input bit ab, input string tag);
        q.push_back('{0, sp_m - 32'd4, {16'd0, fl}, {tag, " R7 flags push"}});
        q.push_back('{0, sp_m - 32'd8, ra, {tag, " R6 R7 return push"}});
        q.push_back('{1, ptr_of(v, prot_mode), {22'd0, ab, ifc, v}, {tag, " R8 R9 entry"}});
        sp_m = sp_m - 32'd8;
        fr_ret.push_back(ra);
        fr_flg.push_back(fl);
    endtask

    task automatic expect_return(input string tag);
        logic [31:0] ra;
        logic [15:0] fl;
        ra = fr_ret.pop_back();
        fl = fr_flg.pop_back();
        q.push_back('{2, ra, {16'd0, fl}, {tag, " R10 return"}});
        sp_m = sp_m + 32'd8;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (mem_req && !in_req) begin
                in_req    = 1'b1;
                req_addr0 = mem_addr;
            end
            if (mem_req && mem_ack) begin
                check(mem_addr == req_addr0, "R11 address held until ack", mem_addr, req_addr0);
                in_req = 1'b0;
            end
            if ((mem_req && mem_we && mem_ack) || handler_valid || ret_valid) begin
                exp_t  e;
                int    k;
                logic [31:0] aa, bb;
                k  = (mem_req && mem_we && mem_ack) ? 0 : (handler_valid ? 1 : 2);
                aa = (k == 0) ? mem_addr : (k == 1) ? handler_ptr : ret_addr;
                bb = (k == 0) ? mem_wdata :
                     (k == 1) ? {22'd0, abort_hit, if_clear, handler_vector} : {16'd0, flags_out};
                if (q.size() == 0) begin
                    check(1'b0, "R2 R4 unexpected event", {29'd0, 3'(k)}, 32'hFFFF_FFFF);
                end else begin
                    e = q.pop_front();
                    check(e.kind == k, {e.tag, " kind"}, {29'd0, 3'(k)}, e.kind);
                    check(e.a == aa,   {e.tag, " address/pointer"}, aa, e.a);
                    check(e.b == bb,   {e.tag, " data/info"}, bb, e.b);
                end
            end
        end
    end

    // ---------------- driver helpers ----------------
    task automatic drain(input string tag);
        int n = 0;
        while (q.size() != 0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(q.size() == 0, {tag, " events completed"}, q.size(), 0);
        q.delete();
        repeat (3) @(negedge clk);
    endtask

    task automatic boundary();
        @(negedge clk) at_boundary = 1'b1;
        @(negedge clk);
        at_boundary = 1'b0;
        exc_valid   = 1'b0;
        swi_valid   = 1'b0;
        intr        = 1'b0;
        iret        = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mem_req || inta_req || handler_valid) seen = 1'b1;
        end
        check(!seen, tag, {31'd0, seen}, 32'd0);
    endtask

    // watchdog
    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!mem_req && !inta_req && !handler_valid && !ret_valid, "R1 reset outputs idle",
              {28'd0, mem_req, inta_req, handler_valid, ret_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // fault, real mode: return = cur_ip; first push at STACK_INIT-4 checks R1 sp
        exc_valid = 1'b1; exc_cls = 2'b00; exc_vector = 8'd14;
        expect_entry(8'd14, flags_in, cur_ip, 1'b0, 1'b0, "R1 R6 fault");
        boundary();
        drain("R6 fault");

        // trap, protected mode: return = next_ip
        prot_mode = 1'b1; cur_ip = 32'h2000; next_ip = 32'h2003;
        exc_valid = 1'b1; exc_cls = 2'b01; exc_vector = 8'd3;
        expect_entry(8'd3, flags_in, next_ip, 1'b0, 1'b0, "R6 R8 trap protected");
        boundary();
        drain("R8 trap");

        // software interrupt, protected, top vector 255
        swi_valid = 1'b1; swi_vector = 8'hFF;
        expect_entry(8'hFF, flags_in, next_ip, 1'b0, 1'b0, "R8 swi vector 255");
        boundary();
        drain("R8 swi");

        // priority: exception beats swi and maskable request
        prot_mode = 1'b0; cur_ip = 32'h3000; next_ip = 32'h3002;
        exc_valid = 1'b1; exc_cls = 2'b00; exc_vector = 8'd6;
        swi_valid = 1'b1; swi_vector = 8'h80; intr = 1'b1;
        expect_entry(8'd6, flags_in, cur_ip, 1'b0, 1'b0, "R2 exception first");
        boundary();
        drain("R2 priority");

        // swi beats NMI: raise NMI edge, then boundary with swi
        nmi = 1'b1;
        repeat (2) @(negedge clk);
        swi_valid = 1'b1; swi_vector = 8'h21;
        expect_entry(8'h21, flags_in, next_ip, 1'b0, 1'b0, "R2 swi before nmi");
        boundary();
        drain("R2 swi nmi");

        // pending NMI taken at next boundary with vector 2, clears IF
        expect_entry(8'd2, flags_in, next_ip, 1'b1, 1'b0, "R4 R9 nmi entry");
        boundary();
        drain("R4 nmi");

        // second edge while blocked: no entry
        nmi = 1'b0;
        @(negedge clk) nmi = 1'b1;
        repeat (2) @(negedge clk);
        boundary();
        quiet(12, "R4 nmi blocked until return");

        // return from NMI handler, then the pending NMI enters
        iret = 1'b1;
        expect_return("R10 nmi handler");
        boundary();
        drain("R10 return");
        expect_entry(8'd2, flags_in, next_ip, 1'b1, 1'b0, "R4 pending nmi after return");
        boundary();
        drain("R4 pending nmi");
        iret = 1'b1;
        expect_return("R10 second nmi");
        boundary();
        drain("R10 second return");

        // maskable with IF clear: ignored
        flags_in = 16'h0002; intr = 1'b1;
        boundary();
        quiet(10, "R3 request ignored when IF clear");

        // maskable with IF set: vector from acknowledge
        flags_in = 16'h0246; intr = 1'b1; inta_vector = 8'h41;
        expect_entry(8'h41, flags_in, next_ip, 1'b1, 1'b0, "R3 R9 maskable");
        boundary();
        drain("R3 maskable");

        // maskable inside string gap: return = cur_ip
        cur_ip = 32'h4000; next_ip = 32'h4002; inta_vector = 8'h60;
        intr = 1'b1;
        expect_entry(8'h60, flags_in, cur_ip, 1'b1, 1'b0, "R5 R6 string gap interrupt");
        @(negedge clk) str_gap = 1'b1;
        @(negedge clk) str_gap = 1'b0; intr = 1'b0;
        drain("R5 gap");

        // exception in a string gap only: ignored
        exc_valid = 1'b1; exc_cls = 2'b00; exc_vector = 8'd13;
        @(negedge clk) str_gap = 1'b1;
        @(negedge clk) str_gap = 1'b0;
        quiet(8, "R5 exception outside boundary ignored");
        exc_valid = 1'b0;
        quiet(4, "R5 no window no entry");

        // abort: return = cur_ip, abort flagged
        exc_valid = 1'b1; exc_cls = 2'b10; exc_vector = 8'd8;
        expect_entry(8'd8, flags_in, cur_ip, 1'b0, 1'b1, "R6 abort");
        boundary();
        drain("R6 abort");

        // return pops last frame, sp restore checked by next entry pushes
        iret = 1'b1;
        expect_return("R10 abort handler");
        boundary();
        drain("R10 abort return");
        swi_valid = 1'b1; swi_vector = 8'h30;
        expect_entry(8'h30, flags_in, next_ip, 1'b0, 1'b0, "R7 R10 stack restored");
        boundary();
        drain("R7 final");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule